// File: doc/BRIEF.md
# DMA Block-Transfer Sequencer

This block runs one DMA channel in block mode. Software-side logic presents a configuration (source and destination start addresses, a stepping mode for each address, the unit width, the side that forms the block area, the block size M and the block count N) and pulses `arm` to load it. Each accepted request then moves one whole block of M units. Each unit is a read from the source followed by a write to the destination. After N blocks the channel raises `done` and a one-cycle `irq`, and it ignores further requests until it is armed again.

The memory side is a valid/ready master port. The sequencer raises `bus_valid` with an address, a direction and, for writes, data. It holds all of these unchanged until the cycle in which `bus_ready` is high. That cycle completes the transfer. `bus_rdata` is sampled in the cycle a read completes. The slave may apply back-pressure for any number of cycles. The sequencer never withdraws a request it has raised.

The size counter reloads from a holding register at the end of every block. At the same point, the block-area address returns to its armed start value. The other address keeps stepping in its own mode. A size value of 0 means 256 units, and a count value of 0 means 65,536 blocks.

Top module: `dma_blk_seq`

## Requirements
- R1: After reset, `bus_valid`, `done` and `irq` are low, and `req` has no effect until `arm` has been pulsed.
- R2: One accepted `req` produces exactly M units and then no bus activity. Each unit is a read at the source address followed directly by a write at the destination address (`bus_write` 0 = read, 1 = write).
- R3: A `req` that arrives while a block is in progress is ignored and does not add a block.
- R4: Each address steps after every unit according to its own mode: 2'b01 increments, 2'b10 decrements, and 2'b00 or 2'b11 keeps it fixed. The step is 1 when `cfg_word`=0 and 2 when `cfg_word`=1, and `bus_word` reports that width.
- R5: At the end of every block, the block-area address (the destination when `cfg_blk_dst`=1, otherwise the source) returns to its armed start value. The other address keeps its stepped value.
- R6: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_write` and `bus_wdata` stay unchanged in the next cycle.
- R7: The 16-bit `bus_wdata` of each write equals the `bus_rdata` accepted by the read of the same unit.
- R8: `cfg_size`=0 gives blocks of 256 units.
- R9: One cycle after the final write of block N completes, `done` rises and `irq` is high for exactly one cycle. Once `done` is high, `req` starts no bus activity.
- R10: An `arm` pulse reloads the configuration and clears `done`, after which requests are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Load configuration, clear done, enable requests |
| cfg_src_start | input | 24 | Source start address |
| cfg_dst_start | input | 24 | Destination start address |
| cfg_src_mode | input | 2 | Source step mode |
| cfg_dst_mode | input | 2 | Destination step mode |
| cfg_word | input | 1 | 1 = word units, 0 = byte units |
| cfg_blk_dst | input | 1 | 1 = destination is block area, 0 = source |
| cfg_size | input | 8 | Block size M (0 = 256) |
| cfg_count | input | 16 | Block count N (0 = 65,536) |
| req | input | 1 | Transfer request, one block each |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus transfer accepted this cycle |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_word | output | 1 | Unit width of the transfer |
| bus_addr | output | 24 | Transfer address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled when a read completes |
| done | output | 1 | All blocks finished |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the last unit of a block under back-pressure. In that unit the size counter reload, the block-side address restore, the block-count decrement and, on the final block, the `done`/`irq` rise all coincide, and new requests must be refused around it. The stimulus drives `bus_ready` from a pseudo-random sequence and repeats `req` every few cycles throughout each block, so stalls and stray requests land on these boundary units. Separate runs cover a 256-unit block, word-wide decrementing addresses, and the block area on each side.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {
    STEP_FIXED = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLD  = 2'b11
  } step_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_READ  = 2'b01,
    PH_WRITE = 2'b10
  } phase_e;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_blk_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic [1:0]    mode,
  input  logic          word,
  input  logic          step,
  input  logic          restore,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] base_q;
  step_mode_e    mode_q;
  logic [AW-1:0] delta;

  assign delta = {{(AW-2){1'b0}}, word, ~word};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      base_q <= '0;
      mode_q <= STEP_FIXED;
    end else if (load) begin
      cur    <= start;
      base_q <= start;
      mode_q <= step_mode_e'(mode);
    end else if (restore) begin
      cur <= base_q;
    end else if (step) begin
      case (mode_q)
        STEP_UP:   cur <= cur + delta;
        STEP_DOWN: cur <= cur - delta;
        default:   cur <= cur;
      endcase
    end
  end
endmodule

// File: rtl/dma_blk_counters.sv
module dma_blk_counters #(
  parameter int SW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] size_in,
  input  logic [CW-1:0] count_in,
  input  logic          unit_done,
  output logic          last_unit,
  output logic          last_block
);
  logic [SW-1:0] hold_q;
  logic [SW-1:0] size_q;
  logic [CW-1:0] blk_q;

  assign last_unit  = (size_q == SW'(1));
  assign last_block = (blk_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      size_q <= '0;
      blk_q  <= '0;
    end else if (load) begin
      hold_q <= size_in;
      size_q <= size_in;
      blk_q  <= count_in;
    end else if (unit_done) begin
      if (last_unit) begin
        size_q <= hold_q;
        blk_q  <= blk_q - CW'(1);
      end else begin
        size_q <= size_q - SW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_blk_fsm.sv
module dma_blk_fsm
  import dma_blk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   arm,
  input  logic   req,
  input  logic   ready,
  input  logic   last_unit,
  input  logic   last_block,
  output phase_e phase,
  output logic   unit_done,
  output logic   rd_take,
  output logic   done,
  output logic   irq
);
  logic armed_q;

  assign unit_done = (phase == PH_WRITE) && ready && !arm;
  assign rd_take   = (phase == PH_READ) && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      armed_q <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else if (arm) begin
      phase   <= PH_IDLE;
      armed_q <= 1'b1;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (phase)
        PH_IDLE:  if (req && armed_q && !done) phase <= PH_READ;
        PH_READ:  if (ready) phase <= PH_WRITE;
        PH_WRITE: if (ready) begin
          if (last_unit) begin
            phase <= PH_IDLE;
            if (last_block) begin
              done <= 1'b1;
              irq  <= 1'b1;
            end
          end else begin
            phase <= PH_READ;
          end
        end
        default:  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
  import dma_blk_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] cfg_src_start,
  input  logic [AW-1:0] cfg_dst_start,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic          cfg_word,
  input  logic          cfg_blk_dst,
  input  logic [SW-1:0] cfg_size,
  input  logic [CW-1:0] cfg_count,
  input  logic          req,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          irq
);
  localparam int NSIDE = 2;

  phase_e        phase;
  logic          unit_done, rd_take, last_unit, last_block, block_end;
  logic          word_q, blk_dst_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] side_start [NSIDE];
  logic [1:0]    side_mode  [NSIDE];
  logic [AW-1:0] side_cur   [NSIDE];

  assign block_end     = unit_done && last_unit;
  assign side_start[0] = cfg_src_start;
  assign side_start[1] = cfg_dst_start;
  assign side_mode[0]  = cfg_src_mode;
  assign side_mode[1]  = cfg_dst_mode;

  dma_blk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .req(req), .ready(bus_ready),
    .last_unit(last_unit), .last_block(last_block), .phase(phase),
    .unit_done(unit_done), .rd_take(rd_take), .done(done), .irq(irq)
  );

  dma_blk_counters #(.SW(SW), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(arm), .size_in(cfg_size),
    .count_in(cfg_count), .unit_done(unit_done),
    .last_unit(last_unit), .last_block(last_block)
  );

  for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
    dma_addr_unit #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(arm), .start(side_start[gi]),
      .mode(side_mode[gi]), .word(word_q), .step(unit_done),
      .restore(block_end && (blk_dst_q == (gi == 1))),
      .cur(side_cur[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= 1'b0;
      blk_dst_q <= 1'b0;
      data_q    <= '0;
    end else begin
      if (arm) begin
        word_q    <= cfg_word;
        blk_dst_q <= cfg_blk_dst;
      end
      if (rd_take) data_q <= bus_rdata;
    end
  end

  assign bus_valid = (phase != PH_IDLE);
  assign bus_write = (phase == PH_WRITE);
  assign bus_word  = word_q;
  assign bus_addr  = bus_write ? side_cur[1] : side_cur[0];
  assign bus_wdata = data_q;
endmodule

// File: rtl/dma_blk_seq_chk.sv
module dma_blk_seq_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          bus_ready,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          done,
  input logic          irq
);
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !arm) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))); // R6

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_ready && !arm) |=> (bus_valid && bus_write)); // R2

  AST_WDATA_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_ready && !arm) |=> (bus_wdata == $past(bus_rdata))); // R7

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9

  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> !bus_valid); // R9
endmodule

bind dma_blk_seq dma_blk_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .bus_ready(bus_ready),
  .bus_rdata(bus_rdata), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done), .irq(irq)
);

// File: tb/dma_blk_seq_test.sv
module dma_blk_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, req = 1'b0, bus_ready = 1'b0;
  logic [23:0] cfg_src_start = '0, cfg_dst_start = '0;
  logic [1:0]  cfg_src_mode = '0, cfg_dst_mode = '0;
  logic        cfg_word = 1'b0, cfg_blk_dst = 1'b0;
  logic [7:0]  cfg_size = '0;
  logic [15:0] cfg_count = '0;
  logic        bus_valid, bus_write, bus_word, done, irq;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

  dma_blk_seq uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_src_start(cfg_src_start),
    .cfg_dst_start(cfg_dst_start), .cfg_src_mode(cfg_src_mode),
    .cfg_dst_mode(cfg_dst_mode), .cfg_word(cfg_word), .cfg_blk_dst(cfg_blk_dst),
    .cfg_size(cfg_size), .cfg_count(cfg_count), .req(req),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .irq(irq)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [23:0] q_addr[$];
  bit          q_wr[$];
  bit          q_last[$];
  logic [23:0] m_src, m_dst, m_src0, m_dst0;
  logic [1:0]  m_ms, m_md;
  bit          m_word, m_bdst, m_armed, done_e, irq_next;
  int          m_size, blocks_left, writes_in_block;
  logic [15:0] last_rd;
  bit          prev_stall;
  logic [23:0] sv_addr;
  logic        sv_write;
  logic [15:0] sv_wdata;
  logic [7:0]  lfsr = 8'h5B;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] step_a(input logic [23:0] a, input logic [1:0] md, input bit w);
    logic [23:0] d = w ? 24'd2 : 24'd1;
    if (md == 2'b01) return a + d;
    if (md == 2'b10) return a - d;
    return a;
  endfunction

  task automatic push_block();
    for (int u = 0; u < m_size; u++) begin
      q_addr.push_back(m_src); q_wr.push_back(1'b0); q_last.push_back(1'b0);
      q_addr.push_back(m_dst); q_wr.push_back(1'b1); q_last.push_back(u == m_size - 1);
      m_src = step_a(m_src, m_ms, m_word);
      m_dst = step_a(m_dst, m_md, m_word);
    end
    if (m_bdst) m_dst = m_dst0; else m_src = m_src0;
    writes_in_block = 0;
  endtask

  // one clock: compare at the falling edge, then drive the next inputs
  task automatic tick(input bit req_i, input bit arm_i);
    bit q_empty;
    bit rdy;
    @(negedge clk);
    cycles++;
    q_empty = (q_addr.size() == 0);
    chk(bus_valid == !q_empty, "R2/R3 bus_valid", bus_valid, !q_empty);
    chk(done == done_e, "R9/R10 done", done, done_e);
    chk(irq == irq_next, "R9 irq", irq, irq_next);
    irq_next = 1'b0;
    if (prev_stall)
      chk(bus_addr == sv_addr && bus_write == sv_write && bus_wdata == sv_wdata,
          "R6 held during stall", bus_addr, sv_addr);
    rdy = arm_i ? 1'b0 : (lfsr[1:0] != 2'b00);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ready = rdy;
    req = req_i;
    arm = arm_i;
    if (arm_i) begin
      m_src = cfg_src_start; m_dst = cfg_dst_start;
      m_src0 = cfg_src_start; m_dst0 = cfg_dst_start;
      m_ms = cfg_src_mode; m_md = cfg_dst_mode;
      m_word = cfg_word; m_bdst = cfg_blk_dst;
      m_size = (cfg_size == 0) ? 256 : int'(cfg_size);
      blocks_left = (cfg_count == 0) ? 65536 : int'(cfg_count);
      m_armed = 1'b1; done_e = 1'b0;
    end
    if (bus_valid && rdy && !q_empty) begin
      logic [23:0] ea = q_addr.pop_front();
      bit ew = q_wr.pop_front();
      bit el = q_last.pop_front();
      chk(bus_write == ew, "R2 direction", bus_write, ew);
      chk(bus_addr == ea, "R4/R5 address", bus_addr, ea);
      chk(bus_word == m_word, "R4 unit width", bus_word, m_word);
      if (ew) begin
        chk(bus_wdata == last_rd, "R7 write data", bus_wdata, last_rd);
        writes_in_block++;
      end else begin
        last_rd = bus_rdata;
      end
      if (el) begin
        chk(writes_in_block == m_size, (m_size == 256) ? "R8 units per block" : "R2 units per block",
            writes_in_block, m_size);
        blocks_left--;
        if (blocks_left == 0) begin
          done_e = 1'b1;
          irq_next = 1'b1;
        end
      end
    end
    prev_stall = bus_valid && !rdy;
    sv_addr = bus_addr; sv_write = bus_write; sv_wdata = bus_wdata;
    if (req_i && q_empty && m_armed && !done_e && !arm_i) push_block();
  endtask

  task automatic run_blocks(input int nreq);
    for (int k = 0; k < nreq; k++) begin
      tick(1'b1, 1'b0);
      for (int c = 0; c < 4000 && (q_addr.size() != 0 || bus_valid); c++)
        tick((c % 5) == 2, 1'b0);  // R3: stray requests while busy
      tick(1'b0, 1'b0);
    end
  endtask

  task automatic configure(input logic [23:0] s, input logic [23:0] d, input logic [1:0] sm,
                           input logic [1:0] dm, input bit w, input bit bd,
                           input logic [7:0] m, input logic [15:0] n);
    cfg_src_start = s; cfg_dst_start = d; cfg_src_mode = sm; cfg_dst_mode = dm;
    cfg_word = w; cfg_blk_dst = bd; cfg_size = m; cfg_count = n;
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    chk(done == 1'b0, "R10 done cleared by arm", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bus_valid == 1'b0 && done == 1'b0 && irq == 1'b0, "R1 reset outputs",
        {bus_valid, done, irq}, 0);
    rst_n = 1'b1;
    // R1: requests before arming have no effect
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0);
    chk(bus_valid == 1'b0, "R1 request before arm", bus_valid, 0);

    // bytes, both ascending, destination is the block area
    configure(24'h001000, 24'h200000, 2'b01, 2'b01, 1'b0, 1'b1, 8'd4, 16'd3);
    run_blocks(3);
    chk(done == 1'b1, "R9 done after final block", done, 1);
    // R9: requests after completion start nothing
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0);
    chk(bus_valid == 1'b0, "R9 request after done", bus_valid, 0);

    // R10 and R4: words, source descending is the block area, destination fixed
    configure(24'h000010, 24'h3F0000, 2'b10, 2'b00, 1'b1, 1'b0, 8'd3, 16'd2);
    run_blocks(2);
    chk(done == 1'b1, "R10 re-armed run completes", done, 1);

    // R8: size 0 means 256 units; destination descending is the block area
    configure(24'hFFFFF0, 24'h000100, 2'b01, 2'b10, 1'b0, 1'b1, 8'd0, 16'd1);
    run_blocks(1);
    chk(done == 1'b1, "R8 long block completes", done, 1);

    // R4 hold mode on the source, R5 with the source as block area
    configure(24'h00ABCD, 24'h100000, 2'b11, 2'b01, 1'b1, 1'b0, 8'd5, 16'd3);
    run_blocks(3);
    chk(done == 1'b1, "R5 run completes", done, 1);

    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", cycles, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule